// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block is the decision core of an eight-line interrupt controller. It watches a set of request pins, captures each rising edge of an unmasked pin as a pending request, and tracks which requests the processor has taken and not yet finished with. It pulses a single-cycle interrupt output toward the processor when a new request, or one left pending after an end-of-interrupt, outranks everything currently in service. Priority is fixed: the higher the line number, the higher the priority.

When the processor acknowledges, the core picks the highest pending line and moves it from pending to in-service. In automatic end-of-interrupt mode it retires that line at once instead. It returns a vector built from a programmable base and the line number. A line that the cascade map marks as fed by a downstream controller, when such a controller is attached, passes that controller's vector through unchanged. All configuration (mask, vector base, mode flag, cascade map) arrives as plain inputs; programming of those values lives elsewhere.

Top module: `irq_prio_core`

## Requirements
- R1: Line numbers run 0 to 7, and when several requests are pending an acknowledge always takes the highest-numbered one.
- R2: A request is captured only on a low-to-high change of its pin compared with the previous clock's sample, with that sample reset to 0. A pin held high is not captured again.
- R3: A rising edge on a pin whose mask bit is 1 is discarded. Clearing the mask later does not bring it back, so a following acknowledge sees no pending request.
- R4: When a request is captured, `irq_pulse` is high for exactly the one cycle after that edge, and only if no in-service bit at that line's position or above is set. If several lines are captured together, one pulse is issued when any of them passes this test.
- R5: With `auto_eoi` at 0, an acknowledge clears the chosen line's pending bit and sets its in-service bit.
- R6: With `auto_eoi` at 1, an acknowledge clears the chosen pending bit without setting its in-service bit. The remaining pending requests are then re-evaluated as after an end-of-interrupt (R9).
- R7: On an acknowledge with a request pending, `vec_out` takes the value `vec_base | line` at that clock edge and holds it until the next acknowledge.
- R8: If the acknowledged line has its `cascade_map` bit set and `slave_present` is 1, `vec_out` takes `slave_vec` instead.
- R9: `eoi_spec` clears the in-service bit given by `eoi_line`. `eoi_nonspec` clears the highest set in-service bit. After either, if any request is pending, `irq_pulse` fires in the next cycle when no in-service bit at or above the highest pending line remains set.
- R10: An acknowledge with nothing pending returns `vec_base | 7` and changes neither the pending nor the in-service bits.
- R11: During reset the pending and in-service bits, `irq_pulse` and `vec_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pin | input | 8 | Request pins, bit n is line n |
| mask | input | 8 | 1 discards rising edges on that line |
| vec_base | input | 8 | Base ORed with the line number |
| auto_eoi | input | 1 | 1 retires a line at acknowledge |
| cascade_map | input | 8 | 1 marks a line fed by a downstream controller |
| slave_present | input | 1 | A downstream controller is attached |
| slave_vec | input | 8 | Vector supplied by the downstream controller |
| eoi_spec | input | 1 | Strobe: retire the line on `eoi_line` |
| eoi_line | input | 3 | Line for `eoi_spec` |
| eoi_nonspec | input | 1 | Strobe: retire the highest in-service line |
| ack | input | 1 | Acknowledge strobe from the processor |
| irq_pulse | output | 1 | One-cycle interrupt signal to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |

## Verification
The hardest state to reach from the ports is the in-service blocking. A pending lower-priority request has to stay silent under an active higher line, and then surface as a pulse only when the last blocking in-service bit is retired. The stimulus reaches it by acknowledging line 2 and then raising line 1, which must stay quiet. Line 6 is raised next and must preempt. The bench then retires lines 6 and 2 with non-specific end-of-interrupt strobes and checks that the pulse appears only after the second. A cycle reference model runs beside the design and compares the pulse and the vector on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned LINES_DEF = 8;
   localparam int unsigned VEC_W_DEF = 8;

   typedef enum logic [1:0] {
      VSRC_NONE,
      VSRC_LOCAL,
      VSRC_SLAVE,
      VSRC_SPUR
   } vec_src_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] new_req_o
);
   logic [N-1:0] pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_i;
   end

   // rising edge of an unmasked pin
   assign new_req_o = pin_i & ~pin_q & ~mask_i;
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
   parameter int unsigned N  = 8,
   localparam int unsigned LW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [LW-1:0] idx_o
);
   initial assert (N >= 2) else $error("irq_prio_find: N must be at least 2");

   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (vec_i[i]) idx_o = LW'(i);
      end
   end
endmodule

// File: rtl/irq_nest_gate.sv
module irq_nest_gate #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] isr_i,
   output logic [N-1:0] free_o
);
   logic [N-1:0] blk;

   // blk[g] = any in-service bit at position g or above
   assign blk[N-1] = isr_i[N-1];
   for (genvar g = 0; g < N - 1; g++) begin : g_chain
      assign blk[g] = isr_i[g] | blk[g+1];
   end

   assign free_o = ~blk;
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
   import irq_prio_pkg::*;
#(
   parameter int unsigned N          = 8,
   parameter int unsigned VW         = 8,
   parameter bit          CASCADE_EN = 1'b1,
   localparam int unsigned LW        = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_i,
   input  logic          any_i,
   input  logic [LW-1:0] idx_i,
   input  logic [VW-1:0] base_i,
   input  logic [N-1:0]  cascade_map_i,
   input  logic          slave_present_i,
   input  logic [VW-1:0] slave_vec_i,
   output logic [VW-1:0] vec_o
);
   vec_src_e src;
   logic     from_slave;

   if (CASCADE_EN) begin : g_cas
      assign from_slave = slave_present_i & cascade_map_i[idx_i];
   end else begin : g_nocas
      logic unused_cas;
      assign unused_cas = ^{cascade_map_i, slave_present_i};
      assign from_slave = 1'b0;
   end

   always_comb begin
      if (!ack_i)          src = VSRC_NONE;
      else if (!any_i)     src = VSRC_SPUR;
      else if (from_slave) src = VSRC_SLAVE;
      else                 src = VSRC_LOCAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vec_o <= '0;
      else begin
         case (src)
            VSRC_SPUR:  vec_o <= base_i | VW'(N - 1);
            VSRC_SLAVE: vec_o <= CASCADE_EN ? slave_vec_i : base_i;
            VSRC_LOCAL: vec_o <= base_i | VW'(idx_i);
            default:    vec_o <= vec_o;
         endcase
      end
   end

   // R8: cascaded line passes the downstream vector through
   a_r8_slave_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (CASCADE_EN && ack_i && any_i && slave_present_i && cascade_map_i[idx_i])
      |=> vec_o == $past(slave_vec_i));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_LINES  = LINES_DEF,
   parameter int unsigned VEC_W      = VEC_W_DEF,
   parameter bit          CASCADE_EN = 1'b1,
   localparam int unsigned LW        = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_pin,
   input  logic [NUM_LINES-1:0] mask,
   input  logic [VEC_W-1:0]     vec_base,
   input  logic                 auto_eoi,
   input  logic [NUM_LINES-1:0] cascade_map,
   input  logic                 slave_present,
   input  logic [VEC_W-1:0]     slave_vec,
   input  logic                 eoi_spec,
   input  logic [LW-1:0]        eoi_line,
   input  logic                 eoi_nonspec,
   input  logic                 ack,
   output logic                 irq_pulse,
   output logic [VEC_W-1:0]     vec_out
);
   localparam int unsigned N = NUM_LINES;

   initial begin
      assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("irq_prio_core: NUM_LINES must be a power of two");
      assert (VEC_W >= LW)
         else $error("irq_prio_core: VEC_W too narrow for a line number");
   end

   logic [N-1:0]  irr_q, isr_q, irr_d, isr_d;
   logic [N-1:0]  new_req, free_cur, free_nxt;
   logic [N-1:0]  irr_clr, isr_clr, isr_set;
   logic          irr_any, isr_any, nxt_any;
   logic [LW-1:0] ack_idx, isr_top, nxt_top;
   logic          ack_take, eoi_evt, latch_hit, eoi_hit;

   irq_pin_edge #(.N(N)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(req_pin), .mask_i(mask), .new_req_o(new_req)
   );

   irq_prio_find #(.N(N)) u_find_req (.vec_i(irr_q), .any_o(irr_any), .idx_o(ack_idx));
   irq_prio_find #(.N(N)) u_find_srv (.vec_i(isr_q), .any_o(isr_any), .idx_o(isr_top));
   irq_prio_find #(.N(N)) u_find_nxt (.vec_i(irr_d), .any_o(nxt_any), .idx_o(nxt_top));

   irq_nest_gate #(.N(N)) u_gate_cur (.isr_i(isr_q), .free_o(free_cur));
   irq_nest_gate #(.N(N)) u_gate_nxt (.isr_i(isr_d), .free_o(free_nxt));

   always_comb begin
      ack_take = ack & irr_any;
      irr_clr  = ack_take ? (N'(1) << ack_idx) : '0;
      isr_set  = (ack_take && !auto_eoi) ? (N'(1) << ack_idx) : '0;
      isr_clr  = '0;
      if (eoi_spec)              isr_clr = isr_clr | (N'(1) << eoi_line);
      if (eoi_nonspec && isr_any) isr_clr = isr_clr | (N'(1) << isr_top);
      irr_d     = (irr_q & ~irr_clr) | new_req;
      isr_d     = (isr_q & ~isr_clr) | isr_set;
      eoi_evt   = eoi_spec | eoi_nonspec | (ack_take & auto_eoi);
      latch_hit = |(new_req & free_cur);
      eoi_hit   = eoi_evt & nxt_any & free_nxt[nxt_top];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         irq_pulse <= 1'b0;
      end else begin
         irr_q     <= irr_d;
         isr_q     <= isr_d;
         irq_pulse <= latch_hit | eoi_hit;
      end
   end

   irq_vec_sel #(.N(N), .VW(VEC_W), .CASCADE_EN(CASCADE_EN)) u_vec (
      .clk(clk), .rst_n(rst_n), .ack_i(ack), .any_i(irr_any), .idx_i(ack_idx),
      .base_i(vec_base), .cascade_map_i(cascade_map), .slave_present_i(slave_present),
      .slave_vec_i(slave_vec), .vec_o(vec_out)
   );

   // R3: a masked line never becomes pending
   a_r3_mask_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_q & ~$past(irr_q) & $past(mask)) == '0);

   // R5: normal acknowledge leaves the line in service
   a_r5_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irr_any && !auto_eoi) |=> isr_q[$past(ack_idx)]);

   // R10: empty acknowledge leaves in-service state alone
   a_r10_spur_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irr_any && !eoi_spec && !eoi_nonspec) |=> $stable(isr_q));

   // R4: a pulse has a capture or end-of-interrupt behind it
   a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past((|new_req) || eoi_evt));

   // R9: specific end-of-interrupt retires its line
   a_r9_spec_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_spec && !(ack && irr_any && !auto_eoi && ack_idx == eoi_line))
      |=> !isr_q[$past(eoi_line)]);
endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_pin = '0, mask = '0, vec_base = 8'h20, cascade_map = '0, slave_vec = '0;
   logic       auto_eoi = 1'b0, slave_present = 1'b0;
   logic       eoi_spec = 1'b0, eoi_nonspec = 1'b0, ack = 1'b0;
   logic [2:0] eoi_line = '0;
   logic       irq_pulse;
   logic [7:0] vec_out;

   int    n_chk = 0, n_fail = 0, pulse_cnt = 0, cyc = 0;
   string cur_req = "R11";

   // reference model state
   logic [7:0] m_irr = '0, m_isr = '0, m_pin = '0, m_vec = '0;
   logic       m_pulse = 1'b0;

   always #10 clk = ~clk;

   irq_prio_core u0 (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .mask(mask), .vec_base(vec_base),
      .auto_eoi(auto_eoi), .cascade_map(cascade_map), .slave_present(slave_present),
      .slave_vec(slave_vec), .eoi_spec(eoi_spec), .eoi_line(eoi_line),
      .eoi_nonspec(eoi_nonspec), .ack(ack), .irq_pulse(irq_pulse), .vec_out(vec_out)
   );

   function automatic int top_bit(logic [7:0] v);
      int r = -1;
      for (int i = 0; i < 8; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic bit clear_above(logic [7:0] s, int line);
      for (int i = line; i < 8; i++) if (s[i]) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_irr = '0; m_isr = '0; m_pin = '0; m_vec = '0; m_pulse = 1'b0;
      end else begin
         logic [7:0] nw, iclr, sclr, sset, irr_n, isr_n;
         bit lat, evt;
         nw = req_pin & ~m_pin & ~mask;
         lat = 1'b0;
         for (int i = 0; i < 8; i++) if (nw[i] && clear_above(m_isr, i)) lat = 1'b1;
         iclr = '0; sclr = '0; sset = '0; evt = 1'b0;
         if (eoi_spec) begin sclr[eoi_line] = 1'b1; evt = 1'b1; end
         if (eoi_nonspec) begin
            evt = 1'b1;
            if (m_isr != 0) sclr[top_bit(m_isr)] = 1'b1;
         end
         if (ack) begin
            if (m_irr != 0) begin
               int l;
               l = top_bit(m_irr);
               iclr[l] = 1'b1;
               if (auto_eoi) evt = 1'b1; else sset[l] = 1'b1;
               m_vec = (slave_present && cascade_map[l]) ? slave_vec : (vec_base | 8'(l));
            end else m_vec = vec_base | 8'd7;
         end
         irr_n = (m_irr & ~iclr) | nw;
         isr_n = (m_isr & ~sclr) | sset;
         m_pulse = lat || (evt && irr_n != 0 && clear_above(isr_n, top_bit(irr_n)));
         m_irr = irr_n; m_isr = isr_n; m_pin = req_pin;
      end
   end

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         check({cur_req, " pulse"}, {7'd0, irq_pulse}, {7'd0, m_pulse});
         check({cur_req, " vector"}, vec_out, m_vec);
         if (irq_pulse) pulse_cnt++;
      end
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic rise(logic [7:0] pins);
      req_pin = req_pin | pins; tick();
      req_pin = req_pin & ~pins; tick();
   endtask

   initial begin
      for (int k = 0; k < 100000; k++) begin
         @(posedge clk);
         cyc++;
      end
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      tick(2);
      check("R11 reset pulse", {7'd0, irq_pulse}, 8'h00);
      check("R11 reset vector", vec_out, 8'h00);
      rst_n = 1'b1; tick();

      // R2 and R4: held pin captured once, single pulse
      cur_req = "R2"; pulse_cnt = 0;
      req_pin[3] = 1'b1; tick(3);
      check("R4 one pulse on capture", 8'(pulse_cnt), 8'd1);
      cur_req = "R7"; do_ack();
      check("R7 vector base|3", vec_out, 8'h23);
      cur_req = "R2"; pulse_cnt = 0; tick(3);
      check("R2 held pin not recaptured", 8'(pulse_cnt), 8'd0);
      req_pin[3] = 1'b0;
      cur_req = "R9"; eoi_line = 3'd3; eoi_spec = 1'b1; tick(); eoi_spec = 1'b0; tick();

      // R3: masked edge dropped, later unmask recovers nothing
      cur_req = "R3"; pulse_cnt = 0;
      mask = 8'h20; rise(8'h20); mask = 8'h00; tick(2);
      check("R3 no pulse for masked edge", 8'(pulse_cnt), 8'd0);
      do_ack();
      check("R3 nothing pending, R10 spurious vector", vec_out, 8'h27);

      // R4, R9: nesting and preemption
      cur_req = "R5"; rise(8'h04); do_ack();
      check("R5 vector base|2", vec_out, 8'h22);
      cur_req = "R4"; pulse_cnt = 0; rise(8'h02);
      check("R4 lower line blocked by in-service 2", 8'(pulse_cnt), 8'd0);
      rise(8'h40);
      check("R4 higher line preempts", 8'(pulse_cnt), 8'd1);
      cur_req = "R1"; do_ack();
      check("R1 highest pending taken", vec_out, 8'h26);
      cur_req = "R9"; pulse_cnt = 0;
      eoi_nonspec = 1'b1; tick(); eoi_nonspec = 1'b0; tick();
      check("R9 line 1 still blocked by 2", 8'(pulse_cnt), 8'd0);
      eoi_nonspec = 1'b1; tick(); eoi_nonspec = 1'b0; tick();
      check("R9 pending line 1 released", 8'(pulse_cnt), 8'd1);
      do_ack();
      check("R9 vector base|1", vec_out, 8'h21);
      eoi_nonspec = 1'b1; tick(); eoi_nonspec = 1'b0; tick();

      // R6: auto end-of-interrupt, simultaneous capture
      cur_req = "R6"; auto_eoi = 1'b1; pulse_cnt = 0;
      rise(8'h14);
      check("R4 two lines at once give one pulse", 8'(pulse_cnt), 8'd1);
      pulse_cnt = 0; do_ack(); tick();
      check("R6 vector base|4", vec_out, 8'h24);
      check("R6 line 2 re-evaluated", 8'(pulse_cnt), 8'd1);
      pulse_cnt = 0; do_ack(); tick();
      check("R6 vector base|2", vec_out, 8'h22);
      check("R6 no pulse when empty", 8'(pulse_cnt), 8'd0);
      rise(8'h01);
      check("R6 nothing left in service", 8'(pulse_cnt), 8'd1);
      do_ack();

      // R8: cascade pass-through
      cur_req = "R8"; cascade_map = 8'h04; slave_present = 1'b1; slave_vec = 8'h75;
      rise(8'h04); do_ack();
      check("R8 slave vector passed", vec_out, 8'h75);
      slave_present = 1'b0; rise(8'h04); do_ack();
      check("R8 no slave gives local vector", vec_out, 8'h22);

      // R1 and R10: ordering, then empty acknowledge
      cur_req = "R1"; rise(8'h2A);
      do_ack(); check("R1 first line 5", vec_out, 8'h25);
      do_ack(); check("R1 then line 3", vec_out, 8'h23);
      do_ack(); check("R1 then line 1", vec_out, 8'h21);
      cur_req = "R10"; pulse_cnt = 0; do_ack(); tick(2);
      check("R10 empty acknowledge vector", vec_out, 8'h27);
      check("R10 no pulse", 8'(pulse_cnt), 8'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule